// File: doc/BRIEF.md
# SYSREF request conditioner with clock-position window capture

This block sits between the sampled external SYSREF request input and the divider and SYSREF logic that consume it. It turns the raw request into an internal request signal under register control. A software trigger can stand in for the pins. A latch mode holds the request high after its first rising edge. A clear control forces the request low in every mode except repeater mode.

The same request edge also drives a windowing circuit. A bank of delayed samples of the input clock, one per analog delay tap, arrives as a tap vector. The circuit is armed by a clear pulse, high and then low. The first rising request edge after arming freezes the tap vector into a 32-bit clock-position snapshot, and both boundary bits of the snapshot always read as set. A helper scans the snapshot for clock rising edges and reports the delay-step setting that places the request midway between the first two edges it finds.

Top module: `sysref_req_window`

## Requirements
- R1: After reset, `req_o` and `done_o` are 0, `snap_o` is 0xFFFFFFFF and `step_o` is 0.
- R2: With latch mode, software trigger and clear all low, `req_o` follows `req_i` one clock edge later.
- R3: While `sw_trig_i` is 1, the effective request is 1 and the level of `req_i` has no effect on `req_o`.
- R4: When `clr_i` is 1 at a clock edge and `repeater_i` is 0, `req_o` is 0 after that edge, even with `sw_trig_i` high. With `repeater_i` at 1, clear does not gate `req_o`.
- R5: With `latch_en_i` at 1, the first rising edge of the effective request sets `req_o` after that edge. `req_o` then stays 1, whatever the input does, until an edge with `clr_i` at 1.
- R6: Capture is armed at the clock edge where `clr_i` is first seen low after being high. The first rising edge of the effective request after arming loads `taps_i` into the snapshot and sets `done_o`, both visible after that edge. Snapshot bit k is the sample of tap k, filled from LSB to MSB.
- R7: Bits 0 and 31 of `snap_o` always read 1, whatever the tap vector holds.
- R8: After a capture, further request edges leave `snap_o` unchanged. Any edge with `clr_i` at 1 reloads `snap_o` with all ones and clears `done_o`.
- R9: No capture happens unless `cap_en_i` is 1 and at least one of `sync_en_i` and `sysref_en_i` is 1. An armed window stays armed while capture is disabled.
- R10: A clock rising edge is marked at index k (0 to 30) where snapshot bits k and k+1 are both 1 and bit k-1 is 0 or k is 0. `step_o` is the floor of the mean of the first two such indices, or 0 if fewer than two exist. It is 6 bits wide, and the delay-step setting runs from 0 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Sampled external request |
| sw_trig_i | input | 1 | Software request trigger |
| latch_en_i | input | 1 | Latch mode enable |
| clr_i | input | 1 | Clear: gates request, resets latch and window |
| repeater_i | input | 1 | Repeater mode select |
| cap_en_i | input | 1 | Clock-position capture enable |
| sync_en_i | input | 1 | Sync path enable |
| sysref_en_i | input | 1 | SYSREF subsystem enable |
| taps_i | input | 32 | Delayed clock samples, one per tap |
| req_o | output | 1 | Conditioned internal request |
| snap_o | output | 32 | Clock-position snapshot |
| done_o | output | 1 | Snapshot captured since last clear |
| step_o | output | 6 | Suggested delay-step setting |

## Verification
A stuck rising-edge detector or arming flag shows one edge after the request rises: `done_o` stays low or rises at the wrong time, and `snap_o` keeps its all-ones value or takes the wrong tap word. A latch or clear gating fault shows on `req_o` one edge after the input change or clear, or after a few idle cycles in latch mode. Faults in the edge locator are combinational. They show on `step_o` in the same cycle the snapshot settles, across tap patterns with zero, one, two and more edges, including runs that touch the boundary bits.

// File: rtl/sreq_pkg.sv
package sreq_pkg;
  localparam int unsigned SNAP_W = 32;
  localparam int unsigned STEP_W = 6;

  typedef struct packed {
    logic latch_en;
    logic clr;
    logic repeater;
  } req_ctrl_t;
endpackage

// File: rtl/sreq_cond.sv
module sreq_cond
  import sreq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  logic      sw_trig_i,
  input  req_ctrl_t ctrl_i,
  output logic      rise_o,
  output logic      req_o
);
  logic req_eff, prev_q, latched_q, req_q;

  assign req_eff = sw_trig_i | pin_i;
  assign rise_o  = req_eff & ~prev_q;
  assign req_o   = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= 1'b0;
      latched_q <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      prev_q <= req_eff;
      if (ctrl_i.clr) latched_q <= 1'b0;
      else if (ctrl_i.latch_en && rise_o) latched_q <= 1'b1;
      // clear gates everything except repeater mode
      if (ctrl_i.clr && !ctrl_i.repeater) req_q <= 1'b0;
      else if (ctrl_i.latch_en) req_q <= latched_q | rise_o;
      else req_q <= req_eff;
    end
  end
endmodule

// File: rtl/sreq_capture.sv
module sreq_capture #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_i,
  input  logic         clr_i,
  input  logic         cap_en_i,
  input  logic [W-1:0] taps_i,
  output logic [W-1:0] snap_o,
  output logic         done_o
);
  localparam logic [W-1:0] EDGE_MASK = {1'b1, {(W-2){1'b0}}, 1'b1};

  logic [W-1:0] snap_q;
  logic clr_q, armed_q, done_q;

  assign snap_o = snap_q | EDGE_MASK;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '1;
      clr_q   <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      clr_q <= clr_i;
      if (clr_i) begin
        snap_q  <= '1;
        armed_q <= 1'b0;
        done_q  <= 1'b0;
      end else begin
        if (clr_q) armed_q <= 1'b1;
        if (armed_q && cap_en_i && rise_i) begin
          snap_q  <= taps_i;
          armed_q <= 1'b0;
          done_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sreq_edge_mid.sv
module sreq_edge_mid #(
  parameter int unsigned W      = 32,
  parameter int unsigned STEP_W = 6
) (
  input  logic [W-1:0]      snap_i,
  output logic [STEP_W-1:0] step_o
);
  localparam int unsigned IDX_W = $clog2(W);

  logic [IDX_W-1:0] e1, e2;
  logic [1:0]       cnt;
  logic             prv;
  logic [IDX_W:0]   sum;

  always_comb begin
    e1  = '0;
    e2  = '0;
    cnt = '0;
    prv = 1'b0;
    for (int k = 0; k < W - 1; k++) begin
      if (snap_i[k] && snap_i[k+1] && !prv) begin
        if (cnt == 2'd0) e1 = IDX_W'(k);
        else if (cnt == 2'd1) e2 = IDX_W'(k);
        if (cnt != 2'd2) cnt = cnt + 2'd1;
      end
      prv = snap_i[k];
    end
    sum = {1'b0, e1} + {1'b0, e2};
  end

  assign step_o = (cnt == 2'd2) ? STEP_W'(sum[IDX_W:1]) : '0;
endmodule

// File: rtl/sysref_req_window.sv
module sysref_req_window
  import sreq_pkg::*;
#(
  parameter int unsigned TAP_W  = SNAP_W,
  parameter int unsigned STEP_WD = STEP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               sw_trig_i,
  input  logic               latch_en_i,
  input  logic               clr_i,
  input  logic               repeater_i,
  input  logic               cap_en_i,
  input  logic               sync_en_i,
  input  logic               sysref_en_i,
  input  logic [TAP_W-1:0]   taps_i,
  output logic               req_o,
  output logic [TAP_W-1:0]   snap_o,
  output logic               done_o,
  output logic [STEP_WD-1:0] step_o
);
  req_ctrl_t ctrl;
  logic rise, cap_ok;

  assign ctrl   = '{latch_en: latch_en_i, clr: clr_i, repeater: repeater_i};
  assign cap_ok = cap_en_i & (sync_en_i | sysref_en_i);

  sreq_cond u_cond (
    .clk_i, .rst_ni,
    .pin_i     (req_i),
    .sw_trig_i (sw_trig_i),
    .ctrl_i    (ctrl),
    .rise_o    (rise),
    .req_o     (req_o)
  );

  sreq_capture #(.W(TAP_W)) u_cap (
    .clk_i, .rst_ni,
    .rise_i   (rise),
    .clr_i    (clr_i),
    .cap_en_i (cap_ok),
    .taps_i   (taps_i),
    .snap_o   (snap_o),
    .done_o   (done_o)
  );

  sreq_edge_mid #(.W(TAP_W), .STEP_W(STEP_WD)) u_mid (
    .snap_i (snap_o),
    .step_o (step_o)
  );
endmodule

// File: rtl/sysref_req_window_chk.sv
module sysref_req_window_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sw_trig_i,
  input logic        latch_en_i,
  input logic        clr_i,
  input logic        repeater_i,
  input logic        sync_en_i,
  input logic        sysref_en_i,
  input logic        req_o,
  input logic [31:0] snap_o,
  input logic        done_o
);
  assert_clr_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !repeater_i) |=> !req_o);

  assert_sw_trig_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_trig_i && !clr_i && !latch_en_i) |=> req_o);

  assert_latch_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_i && $past(latch_en_i) && req_o && !clr_i) |=> req_o);

  assert_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> $stable(snap_o));

  assert_done_after_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_o);

  assert_cap_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !sync_en_i && !sysref_en_i) |=> !done_o);
endmodule

bind sysref_req_window sysref_req_window_chk u_chk (
  .clk_i, .rst_ni, .sw_trig_i, .latch_en_i, .clr_i, .repeater_i,
  .sync_en_i, .sysref_en_i, .req_o, .snap_o, .done_o
);

// File: tb/sysref_req_window_bench.sv
module sysref_req_window_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 9;
  localparam logic [31:0] V_TAPS [0:NV-1] = '{
    32'h0000_0000, 32'h0000_0006, 32'h0003_0006, 32'h00C0_0C00, 32'hC000_0000,
    32'h6000_0030, 32'hFFFF_FFFF, 32'h0000_000C, 32'h0000_300C};
  localparam logic [31:0] V_SNAP [0:NV-1] = '{
    32'h8000_0001, 32'h8000_0007, 32'h8003_0007, 32'h80C0_0C01, 32'hC000_0001,
    32'hE000_0031, 32'hFFFF_FFFF, 32'h8000_000D, 32'h8000_300D};
  localparam logic [5:0] V_STEP [0:NV-1] = '{
    6'd0, 6'd0, 6'd8, 6'd16, 6'd0, 6'd16, 6'd0, 6'd0, 6'd7};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, sw = 0, latch = 0, clr = 0, rep = 0, cap_en = 0, sync_en = 0, sr_en = 0;
  logic [31:0] taps = '0;
  logic req_o, done_o;
  logic [31:0] snap_o;
  logic [5:0]  step_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysref_req_window u_sysref_req_window (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sw_trig_i(sw), .latch_en_i(latch),
    .clr_i(clr), .repeater_i(rep), .cap_en_i(cap_en), .sync_en_i(sync_en),
    .sysref_en_i(sr_en), .taps_i(taps), .req_o(req_o), .snap_o(snap_o),
    .done_o(done_o), .step_o(step_o));

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_clr();
    clr = 1; step(); clr = 0; step();
  endtask

  task automatic fire(logic [31:0] t);
    taps = t; req = 1; step(); req = 0; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(2);
    // R1 reset state
    chk("R1 req_o", 32'(req_o), 0);
    chk("R1 done_o", 32'(done_o), 0);
    chk("R1 snap_o", snap_o, 32'hFFFF_FFFF);
    chk("R1 step_o", 32'(step_o), 0);
    rst_n = 1; step();

    // R6 R7 R10 vector walk
    cap_en = 1; sync_en = 1;
    for (int i = 0; i < NV; i++) begin
      pulse_clr();
      fire(V_TAPS[i]);
      chk($sformatf("R6 done v%0d", i), 32'(done_o), 1);
      chk($sformatf("R7 snap v%0d", i), snap_o, V_SNAP[i]);
      chk($sformatf("R10 step v%0d", i), 32'(step_o), 32'(V_STEP[i]));
    end

    // R8 second edge ignored, clear reloads
    fire(32'h0F0F_0F0F);
    chk("R8 frozen snap", snap_o, V_SNAP[NV-1]);
    chk("R8 frozen done", 32'(done_o), 1);
    clr = 1; step();
    chk("R8 clr snap", snap_o, 32'hFFFF_FFFF);
    chk("R8 clr done", 32'(done_o), 0);
    clr = 0; step();

    // R9 disabled capture, window stays armed
    sync_en = 0; sr_en = 0;
    fire(32'h0000_3000);
    chk("R9 off done", 32'(done_o), 0);
    chk("R9 off snap", snap_o, 32'hFFFF_FFFF);
    sr_en = 1;
    fire(32'h0000_3000);
    chk("R9 sysref_en done", 32'(done_o), 1);
    chk("R9 sysref_en snap", snap_o, 32'h8000_3001);
    pulse_clr();
    cap_en = 0;
    fire(32'h0000_0300);
    chk("R9 cap_en off", 32'(done_o), 0);
    cap_en = 1;

    // R2 pass-through
    req = 1; step();
    chk("R2 high", 32'(req_o), 1);
    req = 0; step();
    chk("R2 low", 32'(req_o), 0);

    // R3 software trigger overrides pins
    sw = 1; step();
    chk("R3 sw high pin low", 32'(req_o), 1);
    req = 1; step(); req = 0; step();
    chk("R3 pin ignored", 32'(req_o), 1);

    // R4 clear gating and repeater exemption
    clr = 1; step();
    chk("R4 clr gates sw", 32'(req_o), 0);
    rep = 1; step();
    chk("R4 repeater passes", 32'(req_o), 1);
    clr = 0; rep = 0; sw = 0; step();
    chk("R4 idle low", 32'(req_o), 0);

    // R5 latch
    latch = 1; step();
    req = 1; step();
    chk("R5 set", 32'(req_o), 1);
    req = 0; step(3);
    chk("R5 held", 32'(req_o), 1);
    clr = 1; step();
    chk("R5 cleared", 32'(req_o), 0);
    clr = 0; step(2);
    chk("R5 stays clear", 32'(req_o), 0);
    latch = 0; step();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule